// File: doc/BRIEF.md
# Issue-Stepped Multiply Pipeline with Register File

This block is a multiply pipeline whose stages move only when a multiply instruction issues. An idle clock leaves the pipe untouched. Each issue reads two source registers and pushes that operand pair into the first stage. In the same step, the value that leaves the last stage is written to the destination register named by the issuing instruction. A result therefore lands in a register chosen by a later instruction. To empty the pipe, software must issue extra multiplies with dummy operands.

The block contains a sixteen-entry, 64-bit register file. Entry 0 is constant zero. There are two forms of the instruction:
- The start form pushes operands and writes nothing.
- The pipelined form pushes operands and retires the oldest result into its destination.

The arithmetic is a stand-in: the unsigned product of the low 32 bits of each operand. A separate load port fills registers from the memory side.

Top module: `issue_mul_pipe`

## Requirements
- R1: A synchronous reset clears every stage valid bit and every register. After reset `wr_en` is low, and a register read after reset yields 0.
- R2: An issue with `piped`=0 (start form) pushes its operands but never produces a register write, even when the last stage holds a valid result.
- R3: An issue with `piped`=1 writes the register named by its own `dst` with the result of the multiply issued STAGES (default 2) issues earlier.
- R4: A result equals the unsigned product of bits [31:0] of the first source and bits [31:0] of the second source, as a 64-bit value.
- R5: Register 0 always reads as 0. A load to index 0 has no effect. A pipelined issue with `dst`=0 produces no write (`wr_en` stays low).
- R6: Without an issue the pipe does not move, and stage contents and valid bits hold across any number of idle cycles. `wr_en` is low in the cycle after an idle cycle.
- R7: A pipelined issue that finds the last stage invalid performs no register write.
- R8: When a pipelined issue names the same register as a source and as its destination, the source operand is the value being written back in that cycle.
- R9: `ld_en` writes `ld_data` into register `ld_idx`. If a multiply write-back targets the same register in the same cycle, the multiply result is kept.
- R10: A write-back appears on `wr_en`/`wr_idx`/`wr_data` during the single cycle after the clock edge at which the issue was sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue | input | 1 | A multiply instruction issues this cycle |
| piped | input | 1 | 1 = pipelined form (retires a result), 0 = start form |
| src_a | input | 4 | First source register index |
| src_b | input | 4 | Second source register index |
| dst | input | 4 | Destination register index for the retiring result |
| ld_en | input | 1 | Load port write enable |
| ld_idx | input | 4 | Load port register index |
| ld_data | input | 64 | Load port data |
| wr_en | output | 1 | Register write-back performed at the previous edge |
| wr_idx | output | 4 | Register written |
| wr_data | output | 64 | Value written |

## Verification
The hardest state to reach from the ports is a pipe that holds valid results while the outputs show nothing. In that state, only a correct record of which earlier issue owns each stage predicts the next write. The stimulus gets there by filling the pipe with two start issues and then leaving long idle gaps before the pipelined issues that retire the results. It also resets in the middle of a run so that retiring issues meet an invalid last stage. Forwarding and the load-versus-multiply conflict are observed indirectly: the affected register is fed back into a later multiply and drained out to a visible destination.

// File: rtl/imp_pkg.sv
package imp_pkg;
   function automatic logic [63:0] low_product(input logic [31:0] a, input logic [31:0] b);
      return 64'(a) * 64'(b);
   endfunction
endpackage

// File: rtl/imp_regfile.sv
module imp_regfile #(
   parameter int DATA_W = 64,
   parameter int REGS   = 16,
   localparam int IDX_W = $clog2(REGS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wa_en,
   input  logic [IDX_W-1:0]  wa_idx,
   input  logic [DATA_W-1:0] wa_data,
   input  logic              wb_en,
   input  logic [IDX_W-1:0]  wb_idx,
   input  logic [DATA_W-1:0] wb_data,
   input  logic [IDX_W-1:0]  ra_idx,
   output logic [DATA_W-1:0] ra_data,
   input  logic [IDX_W-1:0]  rb_idx,
   output logic [DATA_W-1:0] rb_data
);
   if (REGS < 2 || (1 << IDX_W) != REGS) begin : g_bad_regs
      $error("imp_regfile: REGS must be a power of two of at least 2");
   end

   logic [DATA_W-1:0] ent [REGS];

   for (genvar i = 0; i < REGS; i++) begin : g_ent
      if (i == 0) begin : g_zero
         assign ent[i] = '0;
      end else begin : g_flop
         always_ff @(posedge clk) begin
            if (rst)                                ent[i] <= '0;
            else if (wa_en && wa_idx == IDX_W'(i))  ent[i] <= wa_data;
            else if (wb_en && wb_idx == IDX_W'(i))  ent[i] <= wb_data;
         end
      end
   end

   assign ra_data = ent[ra_idx];
   assign rb_data = ent[rb_idx];
endmodule

// File: rtl/imp_stagepipe.sv
module imp_stagepipe #(
   parameter int DATA_W = 64,
   parameter int MUL_W  = 32,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adv,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   output logic              out_vld,
   output logic [DATA_W-1:0] out_data
);
   if (STAGES < 2) begin : g_bad_stages
      $error("imp_stagepipe: STAGES must be at least 2");
   end
   if (MUL_W != 32 || DATA_W != 64) begin : g_bad_width
      $error("imp_stagepipe: the product function expects a 32-bit multiply into 64 bits");
   end

   logic [MUL_W-1:0]  s0_a, s0_b;
   logic              s0_v;
   logic [DATA_W-1:0] pd [1:STAGES-1];
   logic [STAGES-1:1] pv;
   logic              unused_hi;

   assign unused_hi = ^{op_a[DATA_W-1:MUL_W], op_b[DATA_W-1:MUL_W]};

   always_ff @(posedge clk) begin
      if (rst) begin
         s0_v <= 1'b0;
      end else if (adv) begin
         s0_v <= 1'b1;
         s0_a <= op_a[MUL_W-1:0];
         s0_b <= op_b[MUL_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pv[1] <= 1'b0;
      end else if (adv) begin
         pv[1] <= s0_v;
         pd[1] <= imp_pkg::low_product(s0_a, s0_b);
      end
   end

   for (genvar i = 2; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) begin
            pv[i] <= 1'b0;
         end else if (adv) begin
            pv[i] <= pv[i-1];
            pd[i] <= pd[i-1];
         end
      end
   end

   assign out_vld  = pv[STAGES-1];
   assign out_data = pd[STAGES-1];
endmodule

// File: rtl/issue_mul_pipe.sv
module issue_mul_pipe #(
   parameter int DATA_W = 64,
   parameter int REGS   = 16,
   parameter int MUL_W  = 32,
   parameter int STAGES = 2,
   localparam int IDX_W = $clog2(REGS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              issue,
   input  logic              piped,
   input  logic [IDX_W-1:0]  src_a,
   input  logic [IDX_W-1:0]  src_b,
   input  logic [IDX_W-1:0]  dst,
   input  logic              ld_en,
   input  logic [IDX_W-1:0]  ld_idx,
   input  logic [DATA_W-1:0] ld_data,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_data
);
   if (DATA_W < 2 * MUL_W) begin : g_bad_data
      $error("issue_mul_pipe: DATA_W must hold a full product");
   end

   logic              exit_vld;
   logic [DATA_W-1:0] exit_data;
   logic [DATA_W-1:0] rd_a, rd_b, opnd_a, opnd_b;
   logic              wb_fire;

   assign wb_fire = issue && piped && exit_vld && (dst != '0);
   assign opnd_a  = (wb_fire && src_a == dst) ? exit_data : rd_a;
   assign opnd_b  = (wb_fire && src_b == dst) ? exit_data : rd_b;

   imp_regfile #(.DATA_W(DATA_W), .REGS(REGS)) u_rf (
      .clk(clk), .rst(rst),
      .wa_en(wb_fire), .wa_idx(dst), .wa_data(exit_data),
      .wb_en(ld_en), .wb_idx(ld_idx), .wb_data(ld_data),
      .ra_idx(src_a), .ra_data(rd_a),
      .rb_idx(src_b), .rb_data(rd_b)
   );

   imp_stagepipe #(.DATA_W(DATA_W), .MUL_W(MUL_W), .STAGES(STAGES)) u_pipe (
      .clk(clk), .rst(rst), .adv(issue),
      .op_a(opnd_a), .op_b(opnd_b),
      .out_vld(exit_vld), .out_data(exit_data)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_en   <= 1'b0;
         wr_idx  <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= wb_fire;
         if (wb_fire) begin
            wr_idx  <= dst;
            wr_data <= exit_data;
         end
      end
   end
endmodule

// File: rtl/imp_checker.sv
module imp_checker #(
   parameter int IDX_W = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             issue,
   input logic             piped,
   input logic [IDX_W-1:0] dst,
   input logic             exit_vld,
   input logic             wr_en,
   input logic [IDX_W-1:0] wr_idx
);
   a_r2_start_no_write: assert property (@(posedge clk) disable iff (rst)
      (issue && !piped) |=> !wr_en);

   a_r3_retire_to_dst: assert property (@(posedge clk) disable iff (rst)
      (issue && piped && exit_vld && dst != '0) |=> (wr_en && wr_idx == $past(dst)));

   a_r5_no_zero_write: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> (wr_idx != '0));

   a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
      !issue |=> $stable(exit_vld));

   a_r6_idle_no_write: assert property (@(posedge clk) disable iff (rst)
      !issue |=> !wr_en);

   a_r7_empty_no_write: assert property (@(posedge clk) disable iff (rst)
      (issue && !exit_vld) |=> !wr_en);
endmodule

bind issue_mul_pipe imp_checker #(.IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst(rst), .issue(issue), .piped(piped), .dst(dst),
   .exit_vld(exit_vld), .wr_en(wr_en), .wr_idx(wr_idx)
);

// File: tb/issue_mul_pipe_test.sv
module issue_mul_pipe_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        issue = 1'b0, piped = 1'b0;
   logic [3:0]  src_a = '0, src_b = '0, dst = '0;
   logic        ld_en = 1'b0;
   logic [3:0]  ld_idx = '0;
   logic [63:0] ld_data = '0;
   logic        wr_en;
   logic [3:0]  wr_idx;
   logic [63:0] wr_data;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   issue_mul_pipe uut (
      .clk(clk), .rst(rst), .issue(issue), .piped(piped),
      .src_a(src_a), .src_b(src_b), .dst(dst),
      .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
   );

   typedef struct packed {
      logic        p;
      logic [3:0]  a;
      logic [3:0]  b;
      logic [3:0]  d;
      logic        en;
      logic [63:0] data;
   } vec_t;

   // start, start, pipelined, pipelined, drain, drain
   localparam vec_t TBL [6] = '{
      '{1'b0, 4'd1, 4'd2, 4'd15, 1'b0, 64'd0},
      '{1'b0, 4'd3, 4'd4, 4'd15, 1'b0, 64'd0},
      '{1'b1, 4'd5, 4'd6, 4'd9,  1'b1, 64'd15},
      '{1'b1, 4'd7, 4'd8, 4'd10, 1'b1, 64'd63},
      '{1'b1, 4'd0, 4'd0, 4'd11, 1'b1, 64'hFFFF_FFFE_0000_0001},
      '{1'b1, 4'd0, 4'd0, 4'd12, 1'b1, 64'd1234000}
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic load(input logic [3:0] idx, input logic [63:0] val);
      @(negedge clk);
      ld_en = 1'b1; ld_idx = idx; ld_data = val;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   // issue one instruction, sample the write-back after the edge
   task automatic op(input string req, input logic p, input logic [3:0] a, input logic [3:0] b,
                     input logic [3:0] d, input logic e_en, input logic [63:0] e_data);
      @(negedge clk);
      issue = 1'b1; piped = p; src_a = a; src_b = b; dst = d;
      @(posedge clk);
      #1;
      issue = 1'b0; ld_en = 1'b0;
      check({req, " wr_en"}, 64'(wr_en), 64'(e_en));
      if (e_en) begin
         check({req, " wr_idx"}, 64'(wr_idx), 64'(d));
         check({req, " wr_data"}, wr_data, e_data);
      end
   endtask

   task automatic idle_chk(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
         check("R6/R10 idle wr_en", 64'(wr_en), 64'd0);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      do_reset();
      #1;
      check("R1 reset wr_en", 64'(wr_en), 64'd0);

      load(4'd1, 64'd3);
      load(4'd2, 64'd5);
      load(4'd3, 64'h1_0000_0007);   // R4: high half ignored
      load(4'd4, 64'd9);
      load(4'd5, 64'hFFFF_FFFF);
      load(4'd6, 64'hFFFF_FFFF);
      load(4'd7, 64'd1000);
      load(4'd8, 64'd1234);

      // R2 R3 R4: table of start/pipelined/drain issues
      for (int i = 0; i < 6; i++) begin
         op(TBL[i].en ? "R3/R4 table" : "R2 table", TBL[i].p, TBL[i].a, TBL[i].b,
            TBL[i].d, TBL[i].en, TBL[i].data);
      end
      idle_chk(1);

      // R6: long idle gaps with valid contents in the pipe
      op("R2 start", 1'b0, 4'd9, 4'd2, 4'd14, 1'b0, 64'd0);     // 15*5
      idle_chk(5);
      op("R2 start", 1'b0, 4'd10, 4'd0, 4'd14, 1'b0, 64'd0);    // 63*0
      idle_chk(7);
      op("R6 held result", 1'b1, 4'd0, 4'd0, 4'd13, 1'b1, 64'd75);
      op("R5 dst zero", 1'b1, 4'd0, 4'd0, 4'd0, 1'b0, 64'd0);

      // R8: source equals destination of the same issue
      load(4'd14, 64'd6);
      op("R2 start", 1'b0, 4'd14, 4'd2, 4'd1, 1'b0, 64'd0);     // 6*5 = 30
      op("R2 start", 1'b0, 4'd0, 4'd0, 4'd1, 1'b0, 64'd0);
      op("R8 writeback", 1'b1, 4'd15, 4'd2, 4'd15, 1'b1, 64'd30);
      op("R3 drain", 1'b1, 4'd0, 4'd0, 4'd1, 1'b1, 64'd0);
      op("R8 forwarded", 1'b1, 4'd0, 4'd0, 4'd2, 1'b1, 64'd150);

      // R1 R7 R9 R5 after a mid-run reset
      do_reset();
      load(4'd7, 64'd1);
      load(4'd0, 64'd99);
      load(4'd8, 64'd11);
      op("R7 empty exit", 1'b1, 4'd5, 4'd6, 4'd3, 1'b0, 64'd0);
      op("R7 empty exit", 1'b1, 4'd0, 4'd0, 4'd4, 1'b0, 64'd0);
      op("R1 regs cleared", 1'b1, 4'd0, 4'd7, 4'd5, 1'b1, 64'd0);
      @(negedge clk);
      ld_en = 1'b1; ld_idx = 4'd6; ld_data = 64'd777;
      op("R9 conflict wb", 1'b1, 4'd8, 4'd7, 4'd6, 1'b1, 64'd0);
      op("R5 zero read", 1'b1, 4'd6, 4'd7, 4'd9, 1'b1, 64'd0);
      op("R9 load value", 1'b1, 4'd0, 4'd0, 4'd10, 1'b1, 64'd11);
      op("R9 multiply wins", 1'b1, 4'd0, 4'd0, 4'd11, 1'b1, 64'd0);
      idle_chk(2);

      finish_run();
   end
endmodule